// File: doc/BRIEF.md
# Push-Button Byte Editor with Hex Readout

This block lets a person inspect and change a small on-chip memory of sixteen bytes with four push buttons and three seven-segment digits. A pointer selects one location. Two buttons step that pointer forward and backward. The other two buttons add one to or subtract one from the byte at the selected location. Every change is written straight back into the memory.

One digit shows the pointer as a hex character. Two more digits show the selected byte as two hex characters, with the high nibble on the first of them. Each raw button line passes through a two-stage synchroniser and a counter-based debouncer. Each accepted press is then turned into a single action. A press that arrives while another key is also held is dropped.

The digits are driven directly, with no scanning. They show the stored value live, so what is on the display is always the content of the memory at the pointer.

Top module: `membed_top`

## Requirements
- R1: Reset (synchronous, active-high `rst`) clears all sixteen 8-bit locations and the pointer to zero, so the digits read address 0 and byte 00.
- R2: A press on key 0 (`key_raw[0]`, high when pressed) moves the pointer up by one, wrapping from F to 0.
- R3: A press on key 1 moves the pointer down by one, wrapping from 0 to F.
- R4: A press on key 2 adds one to the byte at the pointer and writes it back, wrapping from FF to 00. The new value is on the digits from the next clock cycle.
- R5: A press on key 3 subtracts one from the byte at the pointer and writes it back, wrapping from 00 to FF.
- R6: After a pointer move, the byte digits show the value stored at the new location. Values written earlier are kept when the pointer leaves and returns.
- R7: A press is acted on only when exactly one debounced key is held. Two or more keys becoming active together cause no action.
- R8: A key level is accepted only after the synchronised line differs from the accepted level for 2^DEBOUNCE_W consecutive cycles. A shorter pulse causes no action.
- R9: Each accepted press causes exactly one action, however long the key is held (no auto-repeat).
- R10: Each digit output is active-low, with bit 0 = segment a through bit 6 = segment g. Digit 0 is drawn as 7'b1000000, and the 16 hex glyphs are the usual 0-9, A, b, C, d, E, F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_raw | input | 4 | Raw button lines, high when pressed: 0 addr up, 1 addr down, 2 value up, 3 value down |
| seg_addr | output | 7 | Address digit segments, active-low, bit 0 = a |
| seg_hi | output | 7 | High nibble digit of the selected byte |
| seg_lo | output | 7 | Low nibble digit of the selected byte |

## Verification
A wrong pointer shows at once on the address digit. It also pulls the wrong byte onto the two value digits in the same cycle, because they read the memory combinationally. A bad write-back or a lost location only shows when the pointer comes back to that location, so the bench revisits locations after moving away. Debounce or gating faults show as a missing step or an extra step on the digits, about 2^DEBOUNCE_W plus three cycles after the key edge.

// File: rtl/membed_pkg.sv
package membed_pkg;
   localparam int NUM_KEYS    = 4;
   localparam int K_ADDR_UP   = 0;
   localparam int K_ADDR_DN   = 1;
   localparam int K_VAL_UP    = 2;
   localparam int K_VAL_DN    = 3;
   localparam int SEG_W       = 7;

   // active-high glyph, bit0 = a ... bit6 = g
   function automatic logic [SEG_W-1:0] glyph_of(input logic [3:0] nib);
      logic [SEG_W-1:0] g;
      case (nib)
         4'h0: g = 7'h3F;  4'h1: g = 7'h06;  4'h2: g = 7'h5B;  4'h3: g = 7'h4F;
         4'h4: g = 7'h66;  4'h5: g = 7'h6D;  4'h6: g = 7'h7D;  4'h7: g = 7'h07;
         4'h8: g = 7'h7F;  4'h9: g = 7'h6F;  4'hA: g = 7'h77;  4'hB: g = 7'h7C;
         4'hC: g = 7'h39;  4'hD: g = 7'h5E;  4'hE: g = 7'h79;  default: g = 7'h71;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/key_conditioner.sv
module key_conditioner #(
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_W  = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic level,
   output logic press
);
   localparam logic [DEBOUNCE_W-1:0] CNT_MAX = '1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("key_conditioner: SYNC_STAGES must be at least 2");
   end
   if (DEBOUNCE_W < 1) begin : g_bad_db
      $error("key_conditioner: DEBOUNCE_W must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [DEBOUNCE_W-1:0]  cnt_q;
   logic                   level_q;
   logic                   level_d1_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q     <= '0;
         cnt_q      <= '0;
         level_q    <= 1'b0;
         level_d1_q <= 1'b0;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], raw};
         level_d1_q <= level_q;
         if (sync_q[SYNC_STAGES-1] == level_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_MAX) begin
            cnt_q   <= '0;
            level_q <= sync_q[SYNC_STAGES-1];
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign level = level_q;
   assign press = level_q & ~level_d1_q;
endmodule

// File: rtl/edit_sequencer.sv
module edit_sequencer
   import membed_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_KEYS-1:0] level,
   input  logic [NUM_KEYS-1:0] press,
   input  logic [DATA_W-1:0]   cur_byte,
   output logic [NUM_KEYS-1:0] act,
   output logic [ADDR_W-1:0]   ptr,
   output logic                we,
   output logic [DATA_W-1:0]   wdata
);
   logic               solo;
   logic [ADDR_W-1:0]  ptr_q;

   // exactly one key held at the moment of the edge
   assign solo = (level != '0) && ((level & (level - 1'b1)) == '0);
   assign act  = solo ? (press & level) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= '0;
      end else if (act[K_ADDR_UP]) begin
         ptr_q <= ptr_q + 1'b1;
      end else if (act[K_ADDR_DN]) begin
         ptr_q <= ptr_q - 1'b1;
      end
   end

   always_comb begin
      we    = act[K_VAL_UP] | act[K_VAL_DN];
      wdata = act[K_VAL_UP] ? cur_byte + 1'b1 : cur_byte - 1'b1;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/byte_store.sv
module byte_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/hex_digit.sv
module hex_digit
   import membed_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [3:0]       nib,
   output logic [SEG_W-1:0] seg
);
   logic [SEG_W-1:0] lit;
   assign lit = glyph_of(nib);

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
   end else begin : g_high
      assign seg = lit;
   end
endmodule

// File: rtl/membed_top.sv
module membed_top
   import membed_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_W  = 16,
   parameter bit ACTIVE_LOW  = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_KEYS-1:0] key_raw,
   output logic [SEG_W-1:0]    seg_addr,
   output logic [SEG_W-1:0]    seg_hi,
   output logic [SEG_W-1:0]    seg_lo
);
   if (ADDR_W < 1 || ADDR_W > 4) begin : g_bad_addr
      $error("membed_top: ADDR_W must fit one hex digit (1..4)");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("membed_top: DATA_W must be 8 for two hex digits");
   end

   logic [NUM_KEYS-1:0] level;
   logic [NUM_KEYS-1:0] press;
   logic [NUM_KEYS-1:0] act;
   logic [ADDR_W-1:0]   ptr_q;
   logic                we;
   logic [DATA_W-1:0]   wdata;
   logic [DATA_W-1:0]   cur_byte;
   logic [3:0]          addr_nib;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      key_conditioner #(
         .SYNC_STAGES(SYNC_STAGES),
         .DEBOUNCE_W (DEBOUNCE_W)
      ) u_cond (
         .clk  (clk),
         .rst  (rst),
         .raw  (key_raw[k]),
         .level(level[k]),
         .press(press[k])
      );
   end

   edit_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .level   (level),
      .press   (press),
      .cur_byte(cur_byte),
      .act     (act),
      .ptr     (ptr_q),
      .we      (we),
      .wdata   (wdata)
   );

   byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk  (clk),
      .rst  (rst),
      .we   (we),
      .addr (ptr_q),
      .wdata(wdata),
      .rdata(cur_byte)
   );

   assign addr_nib = 4'(ptr_q);

   hex_digit #(.ACTIVE_LOW(ACTIVE_LOW)) u_dig_addr (.nib(addr_nib),       .seg(seg_addr));
   hex_digit #(.ACTIVE_LOW(ACTIVE_LOW)) u_dig_hi   (.nib(cur_byte[7:4]),  .seg(seg_hi));
   hex_digit #(.ACTIVE_LOW(ACTIVE_LOW)) u_dig_lo   (.nib(cur_byte[3:0]),  .seg(seg_lo));
endmodule

// File: rtl/membed_checker.sv
module membed_checker #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [3:0]        act,
   input logic [ADDR_W-1:0] ptr,
   input logic [DATA_W-1:0] cur_byte
);
   assert_one_action_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(act));

   assert_addr_up_R2: assert property (@(posedge clk) disable iff (rst)
      act[0] |=> ptr == ADDR_W'($past(ptr) + 1'b1));

   assert_addr_dn_R3: assert property (@(posedge clk) disable iff (rst)
      act[1] |=> ptr == ADDR_W'($past(ptr) - 1'b1));

   assert_val_up_R4: assert property (@(posedge clk) disable iff (rst)
      act[2] |=> (cur_byte == DATA_W'($past(cur_byte) + 1'b1)) && $stable(ptr));

   assert_val_dn_R5: assert property (@(posedge clk) disable iff (rst)
      act[3] |=> (cur_byte == DATA_W'($past(cur_byte) - 1'b1)) && $stable(ptr));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (act == 4'b0000) |=> $stable(ptr) && $stable(cur_byte));
endmodule

bind membed_top membed_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .act     (act),
   .ptr     (ptr_q),
   .cur_byte(cur_byte)
);

// File: tb/tb_membed_top.sv
module tb_membed_top;
   localparam int CLK_PERIOD = 10;
   localparam int DB_W       = 3;
   localparam int HOLD       = 30;
   localparam int NVEC       = 12;

   // {keys[3:0], addr[3:0], byte[7:0]} expected after pressing keys
   localparam logic [15:0] VEC [NVEC] = '{
      16'h4_0_01, 16'h4_0_02, 16'h8_0_01, 16'h2_F_00,
      16'h8_F_FF, 16'h1_0_01, 16'h1_1_00, 16'h5_1_00,
      16'h4_1_01, 16'h2_0_01, 16'h2_F_FF, 16'hC_F_FF
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] key_raw = 4'h0;
   logic [6:0] seg_addr, seg_hi, seg_lo;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   membed_top #(.DEBOUNCE_W(DB_W)) dut (
      .clk(clk), .rst(rst), .key_raw(key_raw),
      .seg_addr(seg_addr), .seg_hi(seg_hi), .seg_lo(seg_lo)
   );

   function automatic logic [6:0] exp_seg(input logic [3:0] n);
      logic [6:0] on;
      case (n)
         4'h0: on = 7'b0111111; 4'h1: on = 7'b0000110; 4'h2: on = 7'b1011011;
         4'h3: on = 7'b1001111; 4'h4: on = 7'b1100110; 4'h5: on = 7'b1101101;
         4'h6: on = 7'b1111101; 4'h7: on = 7'b0000111; 4'h8: on = 7'b1111111;
         4'h9: on = 7'b1101111; 4'hA: on = 7'b1110111; 4'hB: on = 7'b1111100;
         4'hC: on = 7'b0111001; 4'hD: on = 7'b1011110; 4'hE: on = 7'b1111001;
         default: on = 7'b1110001;
      endcase
      return ~on;
   endfunction

   task automatic check_disp(input string tag, input logic [3:0] a, input logic [7:0] b);
      n_chk++;
      if (seg_addr !== exp_seg(a)) begin
         n_bad++;
         $display("FAIL %s addr digit: got %b expected %b (addr %h)", tag, seg_addr, exp_seg(a), a);
      end
      n_chk++;
      if ({seg_hi, seg_lo} !== {exp_seg(b[7:4]), exp_seg(b[3:0])}) begin
         n_bad++;
         $display("FAIL %s byte digits: got %b_%b expected %b_%b (byte %h)", tag,
                  seg_hi, seg_lo, exp_seg(b[7:4]), exp_seg(b[3:0]), b);
      end
   endtask

   task automatic press(input logic [3:0] k, input int hold);
      @(negedge clk) key_raw = k;
      repeat (hold) @(negedge clk);
      key_raw = 4'h0;
      repeat (HOLD) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_disp("R1 reset", 4'h0, 8'h00);
      n_chk++;
      if (seg_addr !== 7'b1000000) begin
         n_bad++;
         $display("FAIL R10 glyph 0: got %b expected %b", seg_addr, 7'b1000000);
      end

      // R2 R3 R4 R5 R6 R7 via table
      for (int i = 0; i < NVEC; i++) begin
         press(VEC[i][15:12], HOLD);
         check_disp($sformatf("R2-vector %0d (R3 R4 R5 R6 R7)", i), VEC[i][11:8], VEC[i][7:0]);
      end

      // R4 wrap FF -> 00 at location F
      press(4'h4, HOLD);
      check_disp("R4 wrap", 4'hF, 8'h00);

      // R9 long hold gives one step
      press(4'h4, 200);
      check_disp("R9 no repeat", 4'hF, 8'h01);

      // R8 short pulse ignored
      press(4'h4, 4);
      check_disp("R8 short pulse", 4'hF, 8'h01);

      // R6 earlier value kept at location 0
      press(4'h1, HOLD);
      check_disp("R6 retained", 4'h0, 8'h01);

      // R1 reset clears memory and pointer
      @(negedge clk) rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_disp("R1 re-reset", 4'h0, 8'h00);
      press(4'h2, HOLD);
      check_disp("R1 cleared loc F", 4'hF, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule